// File: doc/BRIEF.md
# Summing Concurrent-Write Shared Memory

This block is a small multi-ported register memory that behaves like an idealised parallel machine memory. Each of its request ports may issue one read or one write per cycle. Reads never stall and return the stored word one cycle after they are accepted. When several ports write the same location in the same cycle, the writes are not arbitrated. They are merged, and the location takes its old contents plus the sum of every write value, as if each write were an atomic fetch-and-add.

A mode input switches the memory to an exclusive-access discipline. In that mode a location serves only one port per cycle. The lowest-numbered requester wins, and the others hold their request with ready low until their turn comes. An accepted write then simply replaces the stored word. The block suits a simulation model or an accelerator that needs combining writes, such as histogram or counter updates from several lanes.

Top module: `crcw_sum_mem`

## Requirements
- R1: After reset every location reads as zero and no port shows a response.
- R2: In concurrent mode (exclMode = 0) every port is ready in every cycle, and any number of ports can read one address in the same cycle and all get the stored word.
- R3: In concurrent mode, the writes accepted in one cycle to one address leave that address holding its previous value plus the sum of all their write data.
- R4: Accumulation wraps modulo 2^WIDTH, with no saturation.
- R5: A read and a write to the same address in the same cycle return the value from before the write. The updated value is returned by reads from the next cycle on.
- R6: Writes to different addresses in the same cycle update each address independently.
- R7: In exclusive mode (exclMode = 1) a request is ready only if no lower-indexed port has a valid request to the same address in that cycle, so the lowest index is served first and each location serves at most one port per cycle.
- R8: In exclusive mode an accepted write replaces the stored word with its data.
- R9: A read accepted on port i (reqValid[i] and reqReady[i] high, reqWrite[i] = 0) gives rspValid[i] high in the next cycle with the data on rspRdata slice i. An accepted write gives no response.
- R10: A location that no accepted write targets keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| exclMode | input | 1 | 0 = concurrent summing mode, 1 = exclusive serialised mode |
| reqValid | input | NPORTS | Request valid, one bit per port |
| reqWrite | input | NPORTS | 1 = write, 0 = read, per port |
| reqAddr | input | NPORTS*ADDR_W | Address, slice i belongs to port i |
| reqWdata | input | NPORTS*WIDTH | Write data, slice i belongs to port i |
| reqReady | output | NPORTS | Request accepted when high together with valid |
| rspValid | output | NPORTS | Read data valid, one cycle after acceptance |
| rspRdata | output | NPORTS*WIDTH | Read data, slice i belongs to port i |

## Verification
The summing path is driven with all ports writing one address, then with repeated accumulation onto a non-zero word. These show whether the contributions are added, whether one writer wins, and whether the old contents are kept. A write pattern that crosses 2^WIDTH separates wrapping from saturation, and writes spread over distinct addresses show whether the per-address combining leaks between locations. Same-cycle read/write pairs separate old-value from forwarded-value reads. In exclusive mode, colliding mixes of reads and writes check the grant order against the lowest-index rule, and the final stored word shows whether a store replaces the old value or adds to it.

// File: rtl/crcw_pkg.sv
package crcw_pkg;

  // Per-port strobes sent from the control to the datapath
  typedef struct packed {
    logic take;        // request accepted this cycle
    logic store;       // accepted request is a write
    logic accumulate;  // write adds to the old word instead of replacing it
  } portStrobe_t;

endpackage

// File: rtl/crcw_ctrl.sv
module crcw_ctrl
  import crcw_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     exclMode,
  input  logic [NPORTS-1:0]        reqValid,
  input  logic [NPORTS-1:0]        reqWrite,
  input  logic [NPORTS*ADDR_W-1:0] reqAddr,
  output logic [NPORTS-1:0]        reqReady,
  output portStrobe_t [NPORTS-1:0] strobes
);

  logic dupGrant;

  // Fixed priority: a port is held off only by a lower-indexed valid
  // request to the same address, and only in exclusive mode.
  always_comb begin
    for (int i = 0; i < NPORTS; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < NPORTS; j++) begin
        if (j < i && exclMode && reqValid[j] &&
            reqAddr[j*ADDR_W +: ADDR_W] == reqAddr[i*ADDR_W +: ADDR_W])
          blocked = 1'b1;
      end
      reqReady[i]           = !blocked;
      strobes[i].take       = reqValid[i] && !blocked;
      strobes[i].store      = reqValid[i] && !blocked && reqWrite[i];
      strobes[i].accumulate = !exclMode;
    end
  end

  // Two accepted requests sharing an address in the same cycle
  always_comb begin
    dupGrant = 1'b0;
    for (int i = 0; i < NPORTS; i++)
      for (int j = 0; j < NPORTS; j++)
        if (i < j && reqValid[i] && reqReady[i] && reqValid[j] && reqReady[j] &&
            reqAddr[i*ADDR_W +: ADDR_W] == reqAddr[j*ADDR_W +: ADDR_W])
          dupGrant = 1'b1;
  end

  a_r7_one_per_location: assert property (@(posedge clk) disable iff (!rstN)
    exclMode |-> !dupGrant);

  a_r7_port0_never_waits: assert property (@(posedge clk) disable iff (!rstN)
    reqValid[0] |-> reqReady[0]);

  a_r2_all_ready: assert property (@(posedge clk) disable iff (!rstN)
    !exclMode |-> (reqReady == {NPORTS{1'b1}}));

endmodule

// File: rtl/crcw_datapath.sv
module crcw_datapath
  import crcw_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int ADDR_W = 4,
  parameter int WIDTH  = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  portStrobe_t [NPORTS-1:0] strobes,
  input  logic [NPORTS*ADDR_W-1:0] reqAddr,
  input  logic [NPORTS*WIDTH-1:0]  reqWdata,
  output logic [NPORTS-1:0]        rspValid,
  output logic [NPORTS*WIDTH-1:0]  rspRdata
);

  logic [WIDTH-1:0] mem   [DEPTH];
  logic [WIDTH-1:0] delta [DEPTH];
  logic [DEPTH-1:0] hit;
  logic [DEPTH-1:0] accum;

  // Per-location sum of every accepted write aimed at it this cycle
  always_comb begin
    for (int a = 0; a < DEPTH; a++) begin
      delta[a] = '0;
      hit[a]   = 1'b0;
      accum[a] = 1'b0;
      for (int i = 0; i < NPORTS; i++) begin
        if (strobes[i].store && reqAddr[i*ADDR_W +: ADDR_W] == ADDR_W'(a)) begin
          delta[a] = delta[a] + reqWdata[i*WIDTH +: WIDTH];
          hit[a]   = 1'b1;
          accum[a] = accum[a] | strobes[i].accumulate;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else begin
      for (int a = 0; a < DEPTH; a++)
        if (hit[a]) mem[a] <= accum[a] ? mem[a] + delta[a] : delta[a];
    end
  end

  // Reads see the word as it stood before this cycle's writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= '0;
      rspRdata <= '0;
    end else begin
      for (int i = 0; i < NPORTS; i++) begin
        rspValid[i] <= strobes[i].take && !strobes[i].store;
        if (strobes[i].take && !strobes[i].store)
          rspRdata[i*WIDTH +: WIDTH] <= mem[reqAddr[i*ADDR_W +: ADDR_W]];
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gHold
    a_r10_untouched_holds: assert property (@(posedge clk) disable iff (!rstN)
      !hit[g] |=> $stable(mem[g]));
  end

endmodule

// File: rtl/crcw_sum_mem.sv
module crcw_sum_mem
  import crcw_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int ADDR_W = 4,
  parameter int WIDTH  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     exclMode,
  input  logic [NPORTS-1:0]        reqValid,
  input  logic [NPORTS-1:0]        reqWrite,
  input  logic [NPORTS*ADDR_W-1:0] reqAddr,
  input  logic [NPORTS*WIDTH-1:0]  reqWdata,
  output logic [NPORTS-1:0]        reqReady,
  output logic [NPORTS-1:0]        rspValid,
  output logic [NPORTS*WIDTH-1:0]  rspRdata
);

  portStrobe_t [NPORTS-1:0] strobes;

  crcw_ctrl #(.NPORTS(NPORTS), .ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .exclMode (exclMode),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqReady (reqReady),
    .strobes  (strobes)
  );

  crcw_datapath #(.NPORTS(NPORTS), .ADDR_W(ADDR_W), .WIDTH(WIDTH)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .rspValid (rspValid),
    .rspRdata (rspRdata)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : gRsp
    a_r9_read_answers: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid[p] && reqReady[p] && !reqWrite[p]) |=> rspValid[p]);
    a_r9_write_silent: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid[p] && reqReady[p] && reqWrite[p]) |=> !rspValid[p]);
  end

endmodule

// File: tb/tb_crcw_sum_mem.sv
module tb_crcw_sum_mem;

  localparam int NP = 4;
  localparam int AW = 4;
  localparam int W  = 16;
  localparam int DEPTH = 1 << AW;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            exclMode = 1'b0;
  logic [NP-1:0]   reqValid = '0;
  logic [NP-1:0]   reqWrite = '0;
  logic [NP*AW-1:0] reqAddr = '0;
  logic [NP*W-1:0]  reqWdata = '0;
  logic [NP-1:0]   reqReady;
  logic [NP-1:0]   rspValid;
  logic [NP*W-1:0]  rspRdata;

  always #5 clk = ~clk;

  crcw_sum_mem #(.NPORTS(NP), .ADDR_W(AW), .WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .exclMode(exclMode),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqReady(reqReady),
    .rspValid(rspValid), .rspRdata(rspRdata)
  );

  typedef struct {
    int          port;
    logic [W-1:0] data;
    string       tag;
  } expItem_t;

  expItem_t     expQ[$];
  logic [W-1:0] model [DEPTH];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [NP-1:0] pValid, pWrite;
  int            pAddr [NP];
  logic [W-1:0]  pData [NP];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic setPort(input int p, input bit wr, input int a, input logic [W-1:0] d);
    pValid[p] = 1'b1;
    pWrite[p] = wr;
    pAddr[p]  = a;
    pData[p]  = d;
  endtask

  // Drive the pending requests until every one is accepted
  task automatic issue(input string tag);
    logic [NP-1:0] pend;
    pend = pValid;
    while (pend != '0) begin
      logic [NP-1:0] expReady, acc;
      logic [W-1:0]  nxt [DEPTH];
      @(negedge clk);
      reqValid = pend;
      reqWrite = pWrite;
      for (int i = 0; i < NP; i++) begin
        reqAddr[i*AW +: AW] = AW'(pAddr[i]);
        reqWdata[i*W +: W]  = pData[i];
      end
      #1;
      for (int i = 0; i < NP; i++) begin
        expReady[i] = 1'b1;
        if (exclMode)
          for (int j = 0; j < i; j++)
            if (pend[j] && pAddr[j] == pAddr[i]) expReady[i] = 1'b0;
      end
      check(reqReady == expReady, exclMode ? "R7" : "R2", {tag, " ready"},
            W'(reqReady), W'(expReady));
      acc = pend & reqReady;
      for (int i = 0; i < NP; i++)
        if (acc[i] && !pWrite[i])
          expQ.push_back('{port: i, data: model[pAddr[i]], tag: tag});
      for (int a = 0; a < DEPTH; a++) nxt[a] = model[a];
      for (int i = 0; i < NP; i++)
        if (acc[i] && pWrite[i])
          nxt[pAddr[i]] = exclMode ? pData[i] : nxt[pAddr[i]] + pData[i];
      for (int a = 0; a < DEPTH; a++) model[a] = nxt[a];
      pend = pend & ~acc;
      @(posedge clk);
    end
    pValid = '0;
    pWrite = '0;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    reqValid = '0;
    repeat (n) @(posedge clk);
  endtask

  // Monitor: compare responses with the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      for (int p = 0; p < NP; p++) begin
        if (rspValid[p]) begin
          if (expQ.size() == 0 || expQ[0].port != p) begin
            check(1'b0, "R9", $sformatf("unexpected response on port %0d", p),
                  W'(1), W'(0));
          end else begin
            expItem_t e;
            e = expQ.pop_front();
            check(rspRdata[p*W +: W] == e.data, e.tag,
                  $sformatf("read data port %0d", p), rspRdata[p*W +: W], e.data);
          end
        end
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    pValid = '0;
    pWrite = '0;
    for (int i = 0; i < NP; i++) begin pAddr[i] = 0; pData[i] = '0; end
    for (int a = 0; a < DEPTH; a++) model[a] = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rspValid == '0, "R1", "rspValid in reset", W'(rspValid), '0);
    rstN = 1'b1;
    @(negedge clk);
    check(rspValid == '0, "R1", "rspValid after reset", W'(rspValid), '0);

    // R1: all locations zero
    for (int b = 0; b < DEPTH; b += NP) begin
      for (int i = 0; i < NP; i++) setPort(i, 1'b0, b + i, '0);
      issue("R1");
    end

    // R3: four writes to one address sum
    for (int i = 0; i < NP; i++) setPort(i, 1'b1, 2, W'(i + 1));
    issue("R3");
    for (int i = 0; i < NP; i++) setPort(i, 1'b1, 2, 16'd5);
    issue("R3");
    // R2: every port reads the same address
    for (int i = 0; i < NP; i++) setPort(i, 1'b0, 2, '0);
    issue("R2");

    // R6: distinct addresses, then read back
    for (int i = 0; i < NP; i++) setPort(i, 1'b1, 8 + i, W'(16'h100 * (i + 1)));
    issue("R6");
    for (int i = 0; i < NP; i++) setPort(i, 1'b0, 8 + i, '0);
    issue("R6");

    // R5: read and write same address in one cycle, then read again
    setPort(0, 1'b1, 4, 16'd9);
    setPort(1, 1'b0, 4, '0);
    setPort(2, 1'b1, 4, 16'd3);
    setPort(3, 1'b0, 2, '0);
    issue("R5");
    setPort(0, 1'b0, 4, '0);
    issue("R5");

    // R9: write-only cycle gives no response
    setPort(0, 1'b1, 6, 16'd1);
    setPort(3, 1'b1, 7, 16'd2);
    issue("R9");
    @(negedge clk);
    reqValid = '0;
    #1;
    check(rspValid == '0, "R9", "response after writes", W'(rspValid), '0);

    // R4: wrap around 2^W
    exclMode = 1'b1;
    setPort(0, 1'b1, 3, 16'hFFF0);
    issue("R8");
    exclMode = 1'b0;
    setPort(0, 1'b1, 3, 16'h0010);
    setPort(1, 1'b1, 3, 16'h0005);
    issue("R4");
    setPort(2, 1'b0, 3, '0);
    issue("R4");

    // R7/R8: exclusive mode, colliding writes and reads
    exclMode = 1'b1;
    for (int i = 0; i < NP; i++) setPort(i, 1'b1, 9, W'(16'h20 + i));
    issue("R7");
    setPort(0, 1'b0, 9, '0);
    setPort(1, 1'b1, 9, 16'h0777);
    setPort(2, 1'b0, 9, '0);
    setPort(3, 1'b1, 10, 16'h0abc);
    issue("R7");
    for (int i = 0; i < NP; i++) setPort(i, 1'b0, 9 + (i % 2), '0);
    issue("R8");
    exclMode = 1'b0;

    // R10: untouched locations keep their values
    setPort(0, 1'b0, 0, '0);
    setPort(1, 1'b0, 15, '0);
    setPort(2, 1'b0, 11, '0);
    setPort(3, 1'b0, 5, '0);
    issue("R10");

    idle(4);
    check(expQ.size() == 0, "R9", "missing responses", W'(expQ.size()), '0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule